// File: doc/BRIEF.md
# UTC to Local Calendar Converter

This block takes a UTC time of day and a UTC date, both as packed BCD digits, from the sentence decoder of a satellite timing receiver. It adds a fixed whole-hour zone offset (eight hours by default, giving UTC+8 local time). When the shifted hour passes midnight, it carries into the day. The day in turn carries into the month and the month into the year, with correct month lengths and leap years. The result is packed into one eight-digit word that a seven-segment scanner can show directly.

A small state machine walks the carry chain one field per clock. It then commits the converted time and date to two output registers together. A free-running timer divides the clock into seconds and flips the displayed view between time and date after a fixed number of seconds. Between input strobes the display keeps the last committed values.

States and transitions:

| State | Description |
|---|---|
| ST_IDLE | Waits for a strobe. A strobe captures the input fields and moves to ST_HOUR. |
| ST_HOUR | Adds the offset to the hour. If the sum reaches 24, it goes to ST_DAY, otherwise to ST_COMMIT. |
| ST_DAY | Increments the day. If the old day was the month's last day, it goes to ST_MONTH, otherwise to ST_COMMIT. |
| ST_MONTH | Increments the month. If the old month was 12, it goes to ST_YEAR, otherwise to ST_COMMIT. |
| ST_YEAR | Increments the four-digit year, then goes to ST_COMMIT. |
| ST_COMMIT | Loads the output registers, then goes to ST_IDLE. |

Top module: `utc_local_clock`

## Requirements
- R1: While reset is low and right after it, `disp_word` is zero and `show_date` is 0 (time view).
- R2: A high `utc_valid`, sampled in the idle state, captures `utc_time` (hour BCD in [23:16], minute in [15:8], second in [7:0]). The committed hour is (UTC hour + ZONE_HOURS) mod 24. Minutes and seconds pass through unchanged.
- R3: In the time view, `disp_word` holds the hour in [31:24], the minute in [19:12] and the second in [7:0], with dash code 4'hA in [23:20] and in [11:8].
- R4: When the offset hour is 24 or more, 24 is subtracted and the day is incremented in BCD, including a ones-digit carry (19 to 20).
- R5: A day equal to the month length wraps to 01 and increments the month. The month lengths are 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R6: February has 29 days when the BCD year is divisible by 4, except years divisible by 100 and not by 400. Otherwise it has 28.
- R7: Month 12 wraps to 01 and the four-digit BCD year increments, carrying through all digits (2099 to 2100, 1999 to 2000).
- R8: In the date view, `disp_word` holds the year in [31:16], the month in [15:8] and the day in [7:0]. This is the same packing as `utc_date`.
- R9: The new values reach the outputs exactly 2 clocks after the strobe edge, plus one clock for each field carried into (day, month, year). Until then the previous values hold.
- R10: `show_date` starts at 0 and toggles every VIEW_SECS × TICKS_PER_SEC clocks after reset.
- R11: A strobe that arrives while a conversion is in progress, including its commit cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| utc_valid | input | 1 | Strobe qualifying `utc_time` and `utc_date` |
| utc_time | input | 24 | UTC hh mm ss, six BCD digits |
| utc_date | input | 32 | UTC date: BCD year [31:16], month [15:8], day [7:0] |
| disp_word | output | 32 | Eight-digit display word for the current view |
| show_date | output | 1 | 1 = date view, 0 = time view |

## Verification
A wrong carry decision in the state machine shows up at the ports in two ways. The word commits one cycle early or late, since the latency counts the carried fields. The date view also shows a wrong day, month or year as soon as the view next shows the date, at most one view period later. A stuck or mis-sized timer counter shifts the first `show_date` flip away from its exact clock count. The bench compares every cycle against a calendar model built on plain integer date arithmetic. It drives month ends, leap and century years, year rollover and strobes that arrive while a conversion is busy.

// File: rtl/utc_pkg.sv
package utc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOUR,
        ST_DAY,
        ST_MONTH,
        ST_YEAR,
        ST_COMMIT
    } conv_state_t;

    localparam logic [3:0] DASH_CODE = 4'hA;

    // Two BCD digits form a multiple of four.
    function automatic logic bcd_pair_div4(input logic [3:0] tens, input logic [3:0] ones);
        if (tens[0])
            return (ones == 4'd2) || (ones == 4'd6);
        else
            return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    endfunction

    function automatic logic [5:0] bcd2_to_bin(input logic [7:0] v);
        return ({2'b00, v[7:4]} * 6'd10) + {2'b00, v[3:0]};
    endfunction

    function automatic logic [7:0] bin_to_bcd2(input logic [5:0] v);
        logic [5:0] t;
        logic [5:0] o;
        t = v / 6'd10;
        o = v % 6'd10;
        return {t[3:0], o[3:0]};
    endfunction

endpackage

// File: rtl/utc_bcd_counter.sv
module utc_bcd_counter #(
    parameter int DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] value,
    output logic [4*DIGITS-1:0] next_value
);
    logic [DIGITS:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic at_nine;
        assign at_nine            = (value[4*i +: 4] == 4'd9);
        assign carry[i+1]         = carry[i] && at_nine;
        assign next_value[4*i +: 4] = (carry[i] && at_nine) ? 4'd0
                                                            : value[4*i +: 4] + {3'b000, carry[i]};
    end

endmodule

// File: rtl/utc_month_len.sv
module utc_month_len (
    input  logic [7:0]  month,
    input  logic [15:0] year,
    output logic [7:0]  last_day
);
    import utc_pkg::*;

    logic leap;

    always_comb begin
        if (year[7:0] == 8'h00)
            leap = bcd_pair_div4(year[15:12], year[11:8]);
        else
            leap = bcd_pair_div4(year[7:4], year[3:0]);
    end

    always_comb begin
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/utc_view_timer.sv
module utc_view_timer #(
    parameter int TICKS_PER_SEC = 50_000_000,
    parameter int VIEW_SECS     = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic show_date,
    output logic view_flip
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int SW = (VIEW_SECS > 1) ? $clog2(VIEW_SECS) : 1;
    localparam logic [CW-1:0] CYC_LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [SW-1:0] SEC_LAST = SW'(VIEW_SECS - 1);

    logic [CW-1:0] cyc_q;
    logic [SW-1:0] sec_q;
    logic          sec_tick;

    assign sec_tick  = (cyc_q == CYC_LAST);
    assign view_flip = sec_tick && (sec_q == SEC_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q     <= '0;
            sec_q     <= '0;
            show_date <= 1'b0;
        end else begin
            cyc_q <= sec_tick ? '0 : cyc_q + 1'b1;
            if (sec_tick)
                sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
            if (view_flip)
                show_date <= ~show_date;
        end
    end

endmodule

// File: rtl/utc_local_clock.sv
module utc_local_clock #(
    parameter int ZONE_HOURS    = 8,
    parameter int TICKS_PER_SEC = 50_000_000,
    parameter int VIEW_SECS     = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        utc_valid,
    input  logic [23:0] utc_time,
    input  logic [31:0] utc_date,
    output logic [31:0] disp_word,
    output logic        show_date
);
    import utc_pkg::*;

    localparam logic [5:0] ZONE = 6'(ZONE_HOURS);

    conv_state_t state_q, state_d;

    logic [7:0]  hr_q, mi_q, se_q, day_q, mon_q;
    logic [15:0] yr_q;
    logic [31:0] time_word_q, date_word_q;

    logic [5:0]  hr_sum;
    logic        hour_wrap;
    logic [7:0]  hr_new;
    logic [7:0]  day_inc, mon_inc, last_day;
    logic [15:0] yr_inc;
    logic        day_wrap, mon_wrap;
    logic        view_flip;
    logic        commit_now;

    // hour arithmetic in binary, back to BCD
    assign hr_sum    = bcd2_to_bin(hr_q) + ZONE;
    assign hour_wrap = (hr_sum >= 6'd24);
    assign hr_new    = bin_to_bcd2(hour_wrap ? hr_sum - 6'd24 : hr_sum);

    utc_month_len i_month_len (
        .month    (mon_q),
        .year     (yr_q),
        .last_day (last_day)
    );

    utc_bcd_counter #(.DIGITS(2)) i_day_inc (.value(day_q), .next_value(day_inc));
    utc_bcd_counter #(.DIGITS(2)) i_mon_inc (.value(mon_q), .next_value(mon_inc));
    utc_bcd_counter #(.DIGITS(4)) i_yr_inc  (.value(yr_q),  .next_value(yr_inc));

    assign day_wrap   = (day_q == last_day);
    assign mon_wrap   = (mon_q == 8'h12);
    assign commit_now = (state_q == ST_COMMIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (utc_valid) state_d = ST_HOUR;
            ST_HOUR:   state_d = hour_wrap ? ST_DAY   : ST_COMMIT;
            ST_DAY:    state_d = day_wrap  ? ST_MONTH : ST_COMMIT;
            ST_MONTH:  state_d = mon_wrap  ? ST_YEAR  : ST_COMMIT;
            ST_YEAR:   state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_q        <= '0;
            mi_q        <= '0;
            se_q        <= '0;
            day_q       <= '0;
            mon_q       <= '0;
            yr_q        <= '0;
            time_word_q <= '0;
            date_word_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (utc_valid) begin
                        hr_q  <= utc_time[23:16];
                        mi_q  <= utc_time[15:8];
                        se_q  <= utc_time[7:0];
                        yr_q  <= utc_date[31:16];
                        mon_q <= utc_date[15:8];
                        day_q <= utc_date[7:0];
                    end
                end
                ST_HOUR:  hr_q  <= hr_new;
                ST_DAY:   day_q <= day_wrap ? 8'h01 : day_inc;
                ST_MONTH: mon_q <= mon_wrap ? 8'h01 : mon_inc;
                ST_YEAR:  yr_q  <= yr_inc;
                ST_COMMIT: begin
                    time_word_q <= {hr_q, DASH_CODE, mi_q, DASH_CODE, se_q};
                    date_word_q <= {yr_q, mon_q, day_q};
                end
                default: ;
            endcase
        end
    end

    utc_view_timer #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .VIEW_SECS     (VIEW_SECS)
    ) i_view_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .show_date (show_date),
        .view_flip (view_flip)
    );

    assign disp_word = show_date ? date_word_q : time_word_q;

endmodule

// File: rtl/utc_local_clock_chk.sv
module utc_local_clock_chk (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 utc_valid,
    input logic [31:0]          disp_word,
    input logic                 show_date,
    input utc_pkg::conv_state_t state,
    input logic                 view_flip,
    input logic                 commit_now
);
    import utc_pkg::*;

    // R3: dash slots filled once a time has been committed
    p_dash_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!show_date && disp_word != 32'h0) |-> (disp_word[23:20] == 4'hA && disp_word[11:8] == 4'hA));

    // R2: local hour stays within 00..23
    p_hour_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!show_date && disp_word != 32'h0) |-> (disp_word[31:24] <= 8'h23 && disp_word[27:24] <= 4'd9));

    // R5: committed day and month stay in range
    p_date_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (show_date && disp_word != 32'h0) |->
            (disp_word[7:0] >= 8'h01 && disp_word[7:0] <= 8'h31 &&
             disp_word[15:8] >= 8'h01 && disp_word[15:8] <= 8'h12));

    // R9: word holds unless a commit happened or the view flipped
    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit_now) && show_date == $past(show_date)) |-> (disp_word == $past(disp_word)));

    // R10: the view only changes after the timer's flip pulse
    p_view_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (show_date != $past(show_date)) |-> $past(view_flip));

    // R11: a running conversion never restarts on a new strobe
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && utc_valid) |=> (state != ST_HOUR));

    // R2: a strobe in idle starts the conversion
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && utc_valid) |=> (state == ST_HOUR));

endmodule

bind utc_local_clock utc_local_clock_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .utc_valid  (utc_valid),
    .disp_word  (disp_word),
    .show_date  (show_date),
    .state      (state_q),
    .view_flip  (view_flip),
    .commit_now (commit_now)
);

// File: tb/test_utc_local_clock.sv
module test_utc_local_clock;

    localparam int ZONE   = 8;
    localparam int TPS    = 10;
    localparam int VSECS  = 5;
    localparam int PERIOD = TPS * VSECS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        utc_valid = 1'b0;
    logic [23:0] utc_time = '0;
    logic [31:0] utc_date = '0;
    logic [31:0] disp_word;
    logic        show_date;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    utc_local_clock #(
        .ZONE_HOURS    (ZONE),
        .TICKS_PER_SEC (TPS),
        .VIEW_SECS     (VSECS)
    ) i_utc_local_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .utc_valid (utc_valid),
        .utc_time  (utc_time),
        .utc_date  (utc_date),
        .disp_word (disp_word),
        .show_date (show_date)
    );

    // ---------------- reference model ----------------
    int          edge_cnt = 0;
    int          busy_left = 0;
    logic [31:0] pend_time, pend_date;
    logic [31:0] exp_time = '0;
    logic [31:0] exp_date = '0;
    string       cur_req = "R1";

    function automatic logic [7:0] to_bcd2(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [15:0] to_bcd4(int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(logic [15:0] v);
        return int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic int days_in(int m, int y);
        bit leap;
        leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        case (m)
            2:             return leap ? 29 : 28;
            4, 6, 9, 11:   return 30;
            default:       return 31;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt  = 0;
            busy_left = 0;
            exp_time  = '0;
            exp_date  = '0;
        end else begin
            edge_cnt++;
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    exp_time = pend_time;
                    exp_date = pend_date;
                end
            end else if (utc_valid) begin
                int h, d, m, y, lat;
                h = from_bcd({8'h00, utc_time[23:16]}) + ZONE;
                d = from_bcd({8'h00, utc_date[7:0]});
                m = from_bcd({8'h00, utc_date[15:8]});
                y = from_bcd(utc_date[31:16]);
                lat = 2;
                if (h >= 24) begin
                    h -= 24; d++; lat++;
                    if (d > days_in(m, y)) begin
                        d = 1; m++; lat++;
                        if (m > 12) begin
                            m = 1; y++; lat++;
                        end
                    end
                end
                pend_time = {to_bcd2(h), 4'hA, utc_time[15:8], 4'hA, utc_time[7:0]};
                pend_date = {to_bcd4(y), to_bcd2(m), to_bcd2(d)};
                busy_left = lat;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic exp_view;
            exp_view = ((edge_cnt / PERIOD) % 2) == 1;
            check({cur_req, "/R10 view"}, {31'b0, show_date}, {31'b0, exp_view});
            check({cur_req, "/R9 word"}, disp_word, exp_view ? exp_date : exp_time);
        end
    end

    task automatic send(string tag, logic [23:0] t, logic [31:0] d);
        @(negedge clk);
        cur_req   = tag;
        utc_time  = t;
        utc_date  = d;
        utc_valid = 1'b1;
        @(negedge clk);
        utc_valid = 1'b0;
        repeat (PERIOD + 3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word", disp_word, 32'h0);
        check("R1 reset view", {31'b0, show_date}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word after reset", disp_word, 32'h0);
        repeat (PERIOD + 5) @(negedge clk);

        send("R2",  24'h030405, 32'h2024_06_15);   // no carry
        send("R2",  24'h155959, 32'h2024_06_15);   // 23, no carry
        send("R3",  24'h160000, 32'h2024_06_15);   // exactly midnight
        send("R4",  24'h203000, 32'h2023_01_19);   // day ones carry
        send("R5",  24'h163000, 32'h2023_04_30);   // 30-day month end
        send("R5",  24'h221111, 32'h2023_07_31);   // 31-day month end
        send("R6",  24'h170000, 32'h2023_02_28);   // plain year
        send("R6",  24'h170000, 32'h2024_02_28);   // leap year
        send("R6",  24'h170000, 32'h2024_02_29);
        send("R6",  24'h180000, 32'h1900_02_28);   // century, not leap
        send("R6",  24'h180000, 32'h2000_02_28);   // 400 rule
        send("R7",  24'h235959, 32'h2099_12_31);
        send("R7",  24'h200102, 32'h1999_12_31);
        send("R8",  24'h010203, 32'h2031_11_05);

        // R11: second strobe during conversion is dropped
        @(negedge clk);
        cur_req   = "R11";
        utc_time  = 24'h235959;
        utc_date  = 32'h2023_12_31;
        utc_valid = 1'b1;
        @(negedge clk);
        utc_time  = 24'h010101;
        utc_date  = 32'h2011_03_03;
        repeat (4) @(negedge clk);
        utc_valid = 1'b0;
        repeat (PERIOD + 3) @(negedge clk);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule